// File: doc/BRIEF.md
# Timing-Speculative Pipeline with Global-Stall Recovery

This block is a five-step in-order pipeline skeleton (fetch, decode, execute, memory, writeback). Each of the four front pipeline registers runs speculatively. It keeps a main copy, which may have captured a late and wrong value, and a shadow copy, which always holds the correct value. When the two copies of a valid slot disagree, that register raises a mismatch flag. All the flags are ORed into a single restore signal. For one cycle, restore stops the global advance. During that cycle every speculative register reloads its main copy from its shadow copy, and the shadow copies hold. The faulty item then continues with correct data and is never re-executed.

A non-speculative stabilization register sits between the last speculative register and the writeback register. Committed results therefore only ever come from data that has been checked. The advance enable stands in for a gated clock edge. Late capture is modelled with injection inputs: for each register, a one-bit enable selects whether the main copy captures the correct value XORed with a shared flip pattern.

Each stage adds a fixed step to the data word: 1, 2, 3 and 4 for registers 0 to 3. A committed result is therefore the input word plus 10, modulo 2^W. A saturating counter records restore events and can be cleared.

Top module: `tsr_pipe`

## Requirements
- R1: A speculative register raises its mismatch flag only if its inject bit was high, with a nonzero `inj_flip`, at an advancing edge that loaded a valid item. `restore` is high in the cycle that follows such an edge.
- R2: `restore` is the OR of all mismatch flags. Flags raised together in several registers cause a single one-cycle restore and a single count.
- R3: `restore` lasts exactly one cycle. During that cycle `in_ready` is low, no input is accepted, and the shadow copies keep their values.
- R4: In the restore cycle each main copy is reloaded from its shadow copy. The committed sequence then matches the error-free sequence: every accepted word plus 10, in order, with no loss and no duplication.
- R5: If every advancing edge corrupts a valid item, the pipeline still accepts one item every two cycles.
- R6: The stabilization register holds during a restore cycle. `wb_valid` is low in the cycle after a restore cycle, so no committed result comes from data that has not been checked.
- R7: `err_count` (16 bits by default) adds one for each restore cycle and saturates at 65535.
- R8: `cnt_clr` sets `err_count` to 0 on the next edge. It wins over a restore event in the same cycle.
- R9: After reset, `wb_valid`, `restore` and `err_count` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_data | input | W | Input word |
| in_ready | output | 1 | Pipeline advances this cycle; input is taken when in_valid is also high |
| inj_en | input | 4 | Per-register late-capture injection (bit k is register k) |
| inj_flip | input | W | XOR pattern applied to a main copy on injection |
| cnt_clr | input | 1 | Clear the restore event counter |
| wb_valid | output | 1 | Committed result valid, one cycle per item |
| wb_data | output | W | Committed result |
| restore | output | 1 | Recovery cycle in progress |
| err_count | output | CNT_W | Saturating restore event count |

## Verification
Two functions can fall in the same cycle: a restore event that wants to raise the counter, and a software clear of that counter. The bench injects a fault and raises `cnt_clr` at the falling edge where `restore` is seen high. It then expects the counter to read zero, not one. The bench also checks that recovery, continuous faults and simultaneous faults in all registers leave the committed sequence identical to an in-order golden list.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  // number of timing-speculative pipeline registers (fetch..memory)
  localparam int unsigned TSR_NSPEC = 4;

  // fixed arithmetic step applied by the logic feeding register k
  function automatic int unsigned stage_step(input int unsigned k);
    return k + 1;
  endfunction
endpackage

// File: rtl/tsr_spec_reg.sv
module tsr_spec_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         d_valid,
  input  logic [W-1:0] d_data,
  input  logic         inj,
  input  logic [W-1:0] flip,
  output logic         q_valid,
  output logic [W-1:0] q_data,
  output logic         err
);
  logic         valid_q, valid_n;
  logic [W-1:0] main_q, main_n;
  logic [W-1:0] shadow_q, shadow_n;

  always_comb begin
    valid_n  = valid_q;
    shadow_n = shadow_q;
    main_n   = shadow_q;
    if (adv) begin
      valid_n  = d_valid;
      shadow_n = d_data;
      main_n   = inj ? (d_data ^ flip) : d_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      main_q   <= '0;
      shadow_q <= '0;
    end else begin
      valid_q  <= valid_n;
      main_q   <= main_n;
      shadow_q <= shadow_n;
    end
  end

  assign q_valid = valid_q;
  assign q_data  = main_q;
  assign err     = valid_q && (main_q != shadow_q);

  assert_clean_after_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> !err);
  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(shadow_q));
  assert_no_inject_no_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !inj) |=> !err);
endmodule

// File: rtl/tsr_restore_ctl.sv
module tsr_restore_ctl #(
  parameter int unsigned NS    = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    err,
  input  logic             cnt_clr,
  output logic             restore,
  output logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign restore = |err;

  always_comb begin
    cnt_n = cnt_q;
    if (cnt_clr)
      cnt_n = '0;
    else if (restore && (cnt_q != CNT_MAX))
      cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign err_count = cnt_q;

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && restore && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_count_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> cnt_q == '0);
endmodule

// File: rtl/tsr_pipe.sv
module tsr_pipe #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [W-1:0]                  in_data,
  output logic                          in_ready,
  input  logic [tsr_pkg::TSR_NSPEC-1:0] inj_en,
  input  logic [W-1:0]                  inj_flip,
  input  logic                          cnt_clr,
  output logic                          wb_valid,
  output logic [W-1:0]                  wb_data,
  output logic                          restore,
  output logic [CNT_W-1:0]              err_count
);
  import tsr_pkg::*;
  localparam int unsigned NS = TSR_NSPEC;

  logic                 adv;
  logic [NS-1:0]        err;
  logic [NS:0]          v_chain;
  logic [NS:0][W-1:0]   d_chain;

  assign adv        = ~restore;
  assign in_ready   = adv;
  assign v_chain[0] = in_valid;
  assign d_chain[0] = in_data;

  for (genvar k = 0; k < NS; k++) begin : g_spec
    logic [W-1:0] stage_in;
    assign stage_in = d_chain[k] + W'(stage_step(k));
    tsr_spec_reg #(.W(W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .d_valid (v_chain[k]),
      .d_data  (stage_in),
      .inj     (inj_en[k]),
      .flip    (inj_flip),
      .q_valid (v_chain[k+1]),
      .q_data  (d_chain[k+1]),
      .err     (err[k])
    );
  end

  tsr_restore_ctl #(.NS(NS), .CNT_W(CNT_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .err       (err),
    .cnt_clr   (cnt_clr),
    .restore   (restore),
    .err_count (err_count)
  );

  // stabilization register (non-speculative) and writeback register
  logic         st_valid_q, st_valid_n;
  logic [W-1:0] st_data_q, st_data_n;
  logic         wb_valid_q, wb_valid_n;
  logic [W-1:0] wb_data_q, wb_data_n;

  always_comb begin
    st_valid_n = st_valid_q;
    st_data_n  = st_data_q;
    wb_data_n  = wb_data_q;
    wb_valid_n = 1'b0;
    if (adv) begin
      st_valid_n = v_chain[NS];
      st_data_n  = d_chain[NS];
      wb_valid_n = st_valid_q;
      wb_data_n  = st_data_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid_q <= 1'b0;
      st_data_q  <= '0;
      wb_valid_q <= 1'b0;
      wb_data_q  <= '0;
    end else begin
      st_valid_q <= st_valid_n;
      st_data_q  <= st_data_n;
      wb_valid_q <= wb_valid_n;
      wb_data_q  <= wb_data_n;
    end
  end

  assign wb_valid = wb_valid_q;
  assign wb_data  = wb_data_q;

  assert_single_cycle_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> !restore);
  assert_no_commit_after_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> !wb_valid);
  assert_stabilizer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> ($stable(st_data_q) && $stable(st_valid_q)));
  assert_or_of_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (err != '0) |-> restore);
endmodule

// File: tb/tsr_pipe_tb_top.sv
module tsr_pipe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready;
  logic [3:0]   inj_en = '0;
  logic [W-1:0] inj_flip = 16'h00A5;
  logic         cnt_clr = 1'b0;
  logic         wb_valid;
  logic [W-1:0] wb_data;
  logic         restore;
  logic [15:0]  err_count;

  tsr_pipe #(.W(W), .CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .inj_en(inj_en), .inj_flip(inj_flip),
    .cnt_clr(cnt_clr), .wb_valid(wb_valid), .wb_data(wb_data),
    .restore(restore), .err_count(err_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit feed = 0;
  logic [W-1:0] tok = 16'h0100;
  logic [W-1:0] gold [16];
  int wr = 0, rd = 0, acc = 0;
  int seq_err = 0, post_err = 0;
  bit prev_restore = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver and commit monitor, both away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (wb_valid) begin
        if (rd == wr || wb_data != gold[rd % 16]) seq_err++;
        rd++;
      end
      if (prev_restore && wb_valid) post_err++;
      prev_restore = restore;
      in_valid = feed;
      in_data  = tok;
      if (feed && in_ready) begin
        gold[wr % 16] = tok + 16'd10;
        wr++;
        acc++;
        tok = tok + 16'd7;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
      finish_run();
    end
  end

  task automatic drain_and_check(input string tag);
    feed = 0;
    repeat (14) @(negedge clk);
    chk(seq_err == 0, "R4", {tag, " commit mismatches"}, seq_err, 0);
    chk(rd == wr, "R4", {tag, " committed count"}, rd, wr);
    chk(post_err == 0, "R6", {tag, " commit right after restore"}, post_err, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(wb_valid == 0, "R9", "wb_valid after reset", wb_valid, 0);
    chk(restore == 0, "R9", "restore after reset", restore, 0);
    chk(err_count == 0, "R9", "err_count after reset", err_count, 0);
    chk(in_ready == 1, "R9", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_clean();
    int c0 = err_count;
    feed = 1;
    repeat (12) @(negedge clk);
    chk(err_count == c0, "R1", "no restore without injection", err_count, c0);
    drain_and_check("clean");
  endtask

  task automatic t_single(input int k);
    int c0;
    feed = 1;
    repeat (7) @(negedge clk);
    c0 = err_count;
    inj_en = 4'(1 << k);
    @(negedge clk);
    inj_en = '0;
    chk(restore == 1, "R1", $sformatf("restore after inject reg %0d", k), restore, 1);
    chk(in_ready == 0, "R3", "in_ready low in restore cycle", in_ready, 0);
    @(negedge clk);
    chk(restore == 0, "R3", "restore lasts one cycle", restore, 0);
    chk(err_count == c0 + 1, "R7", "count step", err_count, c0 + 1);
    drain_and_check($sformatf("single%0d", k));
  endtask

  task automatic t_all();
    int c0;
    feed = 1;
    repeat (7) @(negedge clk);
    c0 = err_count;
    inj_en = 4'hF;
    @(negedge clk);
    inj_en = '0;
    chk(restore == 1, "R2", "restore on all-register fault", restore, 1);
    @(negedge clk);
    chk(restore == 0, "R2", "single restore for joint fault", restore, 0);
    chk(err_count == c0 + 1, "R2", "one count for joint fault", err_count, c0 + 1);
    drain_and_check("all");
  endtask

  task automatic t_clear_coincide();
    feed = 1;
    repeat (7) @(negedge clk);
    inj_en = 4'b0010;
    @(negedge clk);
    inj_en = '0;
    chk(restore == 1, "R8", "restore present with clear", restore, 1);
    cnt_clr = 1;
    @(negedge clk);
    cnt_clr = 0;
    chk(err_count == 0, "R8", "clear wins over event", err_count, 0);
    drain_and_check("clear");
  endtask

  task automatic t_rate();
    int a0;
    feed = 1;
    repeat (7) @(negedge clk);
    inj_en = 4'b0001;
    a0 = acc;
    repeat (200) @(negedge clk);
    inj_en = '0;
    chk((acc - a0) >= 99 && (acc - a0) <= 101, "R5", "accepts under constant faults",
        acc - a0, 100);
    drain_and_check("rate");
  endtask

  task automatic t_sat();
    cnt_clr = 1;
    @(negedge clk);
    cnt_clr = 0;
    feed = 1;
    repeat (6) @(negedge clk);
    inj_en = 4'b0100;
    repeat (131100) @(negedge clk);
    inj_en = '0;
    @(negedge clk);
    chk(err_count == 16'hFFFF, "R7", "saturated count", err_count, 65535);
    drain_and_check("sat");
    cnt_clr = 1;
    @(negedge clk);
    cnt_clr = 0;
    chk(err_count == 0, "R8", "clear after saturation", err_count, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clean();
    for (int k = 0; k < 4; k++) t_single(k);
    t_all();
    t_clear_coincide();
    t_rate();
    t_sat();
    finish_run();
  end
endmodule